// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is one DMA channel. It keeps five 32-bit registers: a source address, a destination address, a pointer to the next descriptor, a control word and a configuration word. Each time an outside arbiter grants it, the channel moves one element. It reads from the source, packs the bytes it reads, and writes one destination beat through a single request/response memory port. It then counts the element off against the count held in the low bits of the control word.

When the count reaches zero, the channel does one of two things. If the next-descriptor pointer is nonzero, it refills its own registers from a four-word descriptor in memory. If the pointer is zero, it switches itself off. If the finished control word asked for it, a one-cycle terminal-count pulse goes to the interrupt logic. The registers are loaded through a simple write port while the channel is idle, and all five are visible on output ports.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset, all five registers read zero. `eligible`, `busy`, `mem_req_valid` and `tc_event` are all low.
- R2: `eligible` is high exactly when the channel is idle, configuration bit 0 (enable) is 1, configuration bit 18 (halt) is 0, and the count in control bits [11:0] is nonzero. A `grant` while `eligible` is high starts one element.
- R3: An element issues reads at the source address with size code = log2 of the source width, then one write at the destination address with size code = log2 of the destination width. Size codes: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. Read data and write data are right-justified on the 32-bit buses.
- R4: The source width is 1 << ctrl[20:18] bytes and the destination width is 1 << ctrl[23:21] bytes; any code above 2 counts as 2. If the destination is wider, dest/source reads are packed little-endian, with the first read in the lowest bytes. If the source is wider, one read is made and its low destination-width bytes are written.
- R5: With ctrl bit 26 set, the source address grows by the source width after each read. With ctrl bit 27 set, the destination address grows by the destination width after each write. With a bit clear, that address stays fixed.
- R6: Each accepted element write lowers ctrl[11:0] by one and leaves ctrl[31:12] unchanged.
- R7: A request is held with a stable address until it is accepted. Only one read is outstanding at a time. The write of an element is issued only after all its read data has returned.
- R8: When the count reaches zero and the next pointer P is nonzero, the channel makes four 4-byte reads, in order, at P, P+4, P+8 and P+12. These load the source, destination, next pointer and control word respectively. The channel stays busy and not eligible until the fourth read returns.
- R9: When the count reaches zero and the next pointer is zero, configuration bit 0 is cleared and every other configuration bit is kept.
- R10: `tc_event` pulses high for one cycle, in the cycle after the final write of a descriptor is accepted, if ctrl bit 31 of that descriptor was set. It stays low otherwise.
- R11: While configuration bit 18 is set, `grant` starts nothing and the registers keep their values.
- R12: A `grant` while the channel is disabled starts nothing.
- R13: Register writes (select 0 source, 1 destination, 2 next pointer, 3 control, 4 configuration) take effect only while the channel is idle. A write made while it is busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 src, 1 dst, 2 next, 3 ctrl, 4 conf) |
| reg_wdata | input | 32 | Register write data |
| grant | input | 1 | Arbiter grant, starts one element when eligible |
| eligible | output | 1 | Channel ready to move an element |
| busy | output | 1 | Element or descriptor fetch in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_size | output | 2 | log2 of access bytes |
| mem_req_wdata | output | 32 | Right-justified write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Right-justified read data |
| tc_event | output | 1 | Terminal-count pulse |
| src_addr | output | 32 | Source address register |
| dst_addr | output | 32 | Destination address register |
| next_ptr | output | 32 | Next-descriptor pointer |
| ctrl_word | output | 32 | Control register |
| conf_word | output | 32 | Configuration register |

## Verification
The engine is driven through several patterns:
- Equal 4-byte widths with both addresses incrementing, which shows plain address stepping and count handling.
- Byte reads packed into word writes, which shows beat ordering and byte placement.
- Word reads truncated into fixed-address halfword writes, which separates the source and destination increment rules.
- Width codes above the legal range, which shows the clamp.
- A chained descriptor, which shows the fetch order and the register reload, and shows that terminal count follows the finishing descriptor's flag.

Halted and disabled grants, and register writes made mid-element, show that nothing moves or changes when it should not. Memory readiness and read latency vary all along, so handshake holding and ordering are exercised under stall.

// File: rtl/dma_chain_channel.sv
module dma_chain_channel #(
  parameter int CNT_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        grant,
  output logic        eligible,
  output logic        busy,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [1:0]  mem_req_size,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        tc_event,
  output logic [31:0] src_addr,
  output logic [31:0] dst_addr,
  output logic [31:0] next_ptr,
  output logic [31:0] ctrl_word,
  output logic [31:0] conf_word
);
  localparam int EN_BIT   = 0;
  localparam int HALT_BIT = 18;
  localparam int SW_LSB   = 18;
  localparam int DW_LSB   = 21;
  localparam int SI_BIT   = 26;
  localparam int DI_BIT   = 27;
  localparam int TC_BIT   = 31;

  typedef enum logic [2:0] {S_IDLE, S_RREQ, S_RRSP, S_WREQ, S_FREQ, S_FRSP} st_t;

  st_t         st;
  logic [31:0] src, dst, nxt, ctl, cfg, fbase, buff;
  logic [1:0]  fidx;
  logic [2:0]  boff, beats;

  function automatic logic [1:0] clampw(input logic [2:0] c);
    return (c > 3'd2) ? 2'd2 : c[1:0];
  endfunction

  function automatic logic [31:0] bmask(input logic [1:0] l);
    return (l == 2'd0) ? 32'h0000_00FF : (l == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  wire [1:0]          sl      = clampw(ctl[SW_LSB+2:SW_LSB]);
  wire [1:0]          dl      = clampw(ctl[DW_LSB+2:DW_LSB]);
  wire [2:0]          sbytes  = 3'd1 << sl;
  wire [2:0]          dbytes  = 3'd1 << dl;
  wire [2:0]          nbeats  = (dl > sl) ? 3'(1 << (dl - sl)) : 3'd1;
  wire [CNT_BITS-1:0] cnt     = ctl[CNT_BITS-1:0];
  wire [CNT_BITS-1:0] cnt_dec = cnt - CNT_BITS'(1);
  wire                idle    = (st == S_IDLE);
  wire                req_hs  = mem_req_valid && mem_req_ready;

  assign eligible      = idle && cfg[EN_BIT] && !cfg[HALT_BIT] && (cnt != '0);
  assign busy          = !idle;
  assign mem_req_valid = (st == S_RREQ) || (st == S_WREQ) || (st == S_FREQ);
  assign mem_req_write = (st == S_WREQ);
  assign mem_req_addr  = (st == S_WREQ) ? dst :
                         (st == S_FREQ) ? fbase + {28'b0, fidx, 2'b00} : src;
  assign mem_req_size  = (st == S_WREQ) ? dl : (st == S_FREQ) ? 2'd2 : sl;
  assign mem_req_wdata = (st == S_WREQ) ? (buff & bmask(dl)) : '0;

  assign src_addr  = src;
  assign dst_addr  = dst;
  assign next_ptr  = nxt;
  assign ctrl_word = ctl;
  assign conf_word = cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      src      <= '0;
      dst      <= '0;
      nxt      <= '0;
      ctl      <= '0;
      cfg      <= '0;
      fbase    <= '0;
      buff     <= '0;
      fidx     <= '0;
      boff     <= '0;
      beats    <= '0;
      tc_event <= 1'b0;
    end else begin
      tc_event <= 1'b0;
      case (st)
        S_IDLE: begin
          if (reg_we) begin
            case (reg_sel)
              3'd0: src <= reg_wdata;
              3'd1: dst <= reg_wdata;
              3'd2: nxt <= reg_wdata;
              3'd3: ctl <= reg_wdata;
              3'd4: cfg <= reg_wdata;
              default: ;
            endcase
          end
          if (grant && eligible) begin
            st    <= S_RREQ;
            buff  <= '0;
            boff  <= '0;
            beats <= nbeats;
          end
        end
        S_RREQ: if (mem_req_ready) st <= S_RRSP;
        S_RRSP: if (mem_rsp_valid) begin
          buff  <= buff | ((mem_rsp_data & bmask(sl)) << {boff, 3'b000});
          boff  <= boff + sbytes;
          beats <= beats - 3'd1;
          if (ctl[SI_BIT]) src <= src + 32'(sbytes);
          st    <= (beats == 3'd1) ? S_WREQ : S_RREQ;
        end
        S_WREQ: if (mem_req_ready) begin
          if (ctl[DI_BIT]) dst <= dst + 32'(dbytes);
          ctl[CNT_BITS-1:0] <= cnt_dec;
          if (cnt_dec == '0) begin
            tc_event <= ctl[TC_BIT];
            if (nxt != '0) begin
              fbase <= nxt;
              fidx  <= 2'd0;
              st    <= S_FREQ;
            end else begin
              cfg[EN_BIT] <= 1'b0;
              st          <= S_IDLE;
            end
          end else begin
            st <= S_IDLE;
          end
        end
        S_FREQ: if (mem_req_ready) st <= S_FRSP;
        S_FRSP: if (mem_rsp_valid) begin
          case (fidx)
            2'd0: src <= mem_rsp_data;
            2'd1: dst <= mem_rsp_data;
            2'd2: nxt <= mem_rsp_data;
            default: ctl <= mem_rsp_data;
          endcase
          if (fidx == 2'd3) st <= S_IDLE;
          else begin
            fidx <= fidx + 2'd1;
            st   <= S_FREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R10
  tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_event |=> !tc_event);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_hs && mem_req_write |=>
      (ctrl_word[CNT_BITS-1:0] == CNT_BITS'($past(ctrl_word[CNT_BITS-1:0]) - CNT_BITS'(1))) &&
      (ctrl_word[31:CNT_BITS] == $past(ctrl_word[31:CNT_BITS])));

  // R9
  self_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_hs && mem_req_write && (ctrl_word[CNT_BITS-1:0] == CNT_BITS'(1)) && (next_ptr == '0)
      |=> !conf_word[EN_BIT]);

  // R2
  quiet_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eligible |-> !mem_req_valid);
endmodule

// File: tb/dma_chain_channel_bench.sv
module dma_chain_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        grant = 1'b0;
  logic        eligible, busy;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        tc_event;
  logic [31:0] src_addr, dst_addr, next_ptr, ctrl_word, conf_word;

  always #4 clk = ~clk;

  dma_chain_channel u_dma_chain_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .grant(grant), .eligible(eligible), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .tc_event(tc_event),
    .src_addr(src_addr), .dst_addr(dst_addr), .next_ptr(next_ptr),
    .ctrl_word(ctrl_word), .conf_word(conf_word)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int lat = 0;
  int rcnt = 0;
  bit pend = 1'b0;
  bit tc_due = 1'b0;
  bit done = 1'b0;
  logic [31:0] pdata = '0;
  logic [7:0]  mem [0:1023];
  logic [67:0] expq [$];
  logic [31:0] m_src = '0, m_dst = '0, m_nxt = '0, m_ctl = '0, m_cfg = '0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r |= 32'(mem[(a + 32'(i)) & 32'd1023]) << (8 * i);
    return r;
  endfunction

  task automatic poke32(input logic [31:0] a, input logic [31:0] d);
    for (int i = 0; i < 4; i++) mem[(a + 32'(i)) & 32'd1023] = d[8*i +: 8];
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [67:0] e;
      cyc++;
      // R10 terminal-count pulse timing
      if (tc_event || tc_due) chk(tc_event == tc_due, "R10 tc_event", 32'(tc_event), 32'(tc_due));
      tc_due = 1'b0;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (rcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = pdata;
          pend = 1'b0;
        end else rcnt--;
      end
      mem_req_ready = (cyc % 4) != 2;
      if (mem_req_valid && mem_req_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R12 R11 unexpected memory request", mem_req_addr, 32'h0);
        end else begin
          e = expq.pop_front();
          chk(mem_req_write == e[66], "R3 R8 request direction", 32'(mem_req_write), 32'(e[66]));
          chk(mem_req_addr == e[63:32], "R3 R5 R8 request address", mem_req_addr, e[63:32]);
          chk(mem_req_size == e[65:64], "R3 R4 request size", 32'(mem_req_size), 32'(e[65:64]));
          if (e[66]) chk(mem_req_wdata == e[31:0], "R4 write data", mem_req_wdata, e[31:0]);
        end
        if (mem_req_write) begin
          // R7 no read outstanding when writing
          chk(!pend, "R7 write with read outstanding", 32'(pend), 32'h0);
          for (int i = 0; i < (1 << mem_req_size); i++)
            mem[(mem_req_addr + 32'(i)) & 32'd1023] = mem_req_wdata[8*i +: 8];
          if (expq.size() >= 0 && e[67]) tc_due = 1'b1;
        end else begin
          pend = 1'b1;
          rcnt = lat;
          lat = (lat + 1) % 3;
          pdata = rd(mem_req_addr, 1 << mem_req_size);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] d, input bit model);
    reg_sel = sel;
    reg_wdata = d;
    reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
    if (model) begin
      case (sel)
        3'd0: m_src = d;
        3'd1: m_dst = d;
        3'd2: m_nxt = d;
        3'd3: m_ctl = d;
        3'd4: m_cfg = d;
        default: ;
      endcase
    end
  endtask

  task automatic plan_element();
    int sl, dl, sb, db, nb;
    logic [31:0] acc, d, base;
    logic [11:0] c;
    sl = (m_ctl[20:18] > 3'd2) ? 2 : int'(m_ctl[20:18]);
    dl = (m_ctl[23:21] > 3'd2) ? 2 : int'(m_ctl[23:21]);
    sb = 1 << sl;
    db = 1 << dl;
    nb = (db > sb) ? db / sb : 1;
    acc = '0;
    for (int b = 0; b < nb; b++) begin
      d = rd(m_src, sb);
      acc |= d << (8 * b * sb);
      expq.push_back({1'b0, 1'b0, 2'(sl), m_src, 32'h0});
      if (m_ctl[26]) m_src += 32'(sb);
    end
    if (db < 4) acc &= (32'h1 << (8 * db)) - 32'h1;
    c = m_ctl[11:0] - 12'd1;
    expq.push_back({(c == '0) && m_ctl[31], 1'b1, 2'(dl), m_dst, acc});
    if (m_ctl[27]) m_dst += 32'(db);
    m_ctl[11:0] = c;
    if (c == '0) begin
      if (m_nxt != '0) begin
        base = m_nxt;
        for (int k = 0; k < 4; k++) expq.push_back({1'b0, 1'b0, 2'd2, base + 32'(4 * k), 32'h0});
        m_src = rd(base, 4);
        m_dst = rd(base + 32'd4, 4);
        m_nxt = rd(base + 32'd8, 4);
        m_ctl = rd(base + 32'd12, 4);
      end else m_cfg[0] = 1'b0;
    end
  endtask

  task automatic cmp_regs(input string tag);
    chk(src_addr == m_src, {"R5 R8 src register ", tag}, src_addr, m_src);
    chk(dst_addr == m_dst, {"R5 R8 dst register ", tag}, dst_addr, m_dst);
    chk(next_ptr == m_nxt, {"R8 next register ", tag}, next_ptr, m_nxt);
    chk(ctrl_word == m_ctl, {"R6 R13 ctrl register ", tag}, ctrl_word, m_ctl);
    chk(conf_word == m_cfg, {"R9 conf register ", tag}, conf_word, m_cfg);
  endtask

  task automatic run_element(input bit poke, input string tag);
    chk(eligible == 1'b1, {"R2 eligible before grant ", tag}, 32'(eligible), 32'h1);
    plan_element();
    grant = 1'b1;
    tick();
    grant = 1'b0;
    if (poke) begin
      // R13 writes while busy must be dropped
      wreg(3'd3, 32'hDEAD_0FFF, 1'b0);
      wreg(3'd4, 32'h0004_0000, 1'b0);
    end
    for (int t = 0; t < 200; t++) begin
      if (!busy && expq.size() == 0) break;
      if (busy) chk(!eligible, {"R8 not eligible while busy ", tag}, 32'(eligible), 32'h0);
      tick();
    end
    chk(expq.size() == 0, {"R3 all transactions seen ", tag}, 32'(expq.size()), 32'h0);
    tick();
    cmp_regs(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    repeat (4) tick();
    // R1 reset state
    chk(!mem_req_valid && !tc_event && !eligible && !busy, "R1 outputs in reset", {28'h0, mem_req_valid, tc_event, eligible, busy}, 32'h0);
    rst_n = 1'b1;
    tick();
    chk(src_addr == 0 && dst_addr == 0 && next_ptr == 0, "R1 address registers after reset", src_addr | dst_addr | next_ptr, 32'h0);
    chk(ctrl_word == 0 && conf_word == 0, "R1 ctrl and conf after reset", ctrl_word | conf_word, 32'h0);

    // R12 disabled channel ignores grant
    wreg(3'd3, 32'h0000_0005, 1'b1);
    chk(!eligible, "R12 eligible while disabled", 32'(eligible), 32'h0);
    grant = 1'b1; tick(); grant = 1'b0;
    repeat (5) tick();
    chk(!busy, "R12 busy after disabled grant", 32'(busy), 32'h0);
    cmp_regs("disabled");

    // Word copy, both increments, tc on last
    wreg(3'd0, 32'h100, 1'b1);
    wreg(3'd1, 32'h200, 1'b1);
    wreg(3'd2, 32'h0, 1'b1);
    wreg(3'd3, 32'h8C90_0003, 1'b1);
    wreg(3'd4, 32'h0000_0001, 1'b1);
    for (int k = 0; k < 3; k++) run_element(1'b0, "word copy");
    chk(!eligible, "R9 R2 eligible after chain end", 32'(eligible), 32'h0);

    // R4 byte reads packed into words
    wreg(3'd0, 32'h140, 1'b1);
    wreg(3'd1, 32'h240, 1'b1);
    wreg(3'd3, 32'h0C40_0002, 1'b1);
    wreg(3'd4, 32'h0000_0021, 1'b1);
    for (int k = 0; k < 2; k++) run_element(1'b0, "byte pack");

    // R4 R5 word reads truncated to halfwords, fixed destination
    wreg(3'd0, 32'h180, 1'b1);
    wreg(3'd1, 32'h280, 1'b1);
    wreg(3'd3, 32'h0428_0002, 1'b1);
    wreg(3'd4, 32'h0000_0001, 1'b1);
    for (int k = 0; k < 2; k++) run_element(1'b0, "truncate");

    // R4 oversize width codes clamp to 4 bytes
    wreg(3'd0, 32'h1C0, 1'b1);
    wreg(3'd1, 32'h2C0, 1'b1);
    wreg(3'd3, 32'h8CBC_0001, 1'b1);
    wreg(3'd4, 32'h0000_0001, 1'b1);
    run_element(1'b0, "clamp");

    // R11 halt blocks grants
    wreg(3'd3, 32'h0C90_0001, 1'b1);
    wreg(3'd4, 32'h0004_0001, 1'b1);
    chk(!eligible, "R11 eligible while halted", 32'(eligible), 32'h0);
    grant = 1'b1; tick(); grant = 1'b0;
    repeat (5) tick();
    chk(!busy, "R11 busy after halted grant", 32'(busy), 32'h0);
    cmp_regs("halted");
    wreg(3'd4, 32'h0000_0001, 1'b1);
    run_element(1'b0, "after halt");

    // R8 linked descriptor fetch
    poke32(32'h300, 32'h1A0);
    poke32(32'h304, 32'h2E0);
    poke32(32'h308, 32'h0);
    poke32(32'h30C, 32'h8C90_0002);
    wreg(3'd0, 32'h110, 1'b1);
    wreg(3'd1, 32'h210, 1'b1);
    wreg(3'd2, 32'h300, 1'b1);
    wreg(3'd3, 32'h0C90_0001, 1'b1);
    wreg(3'd4, 32'h0000_0101, 1'b1);
    run_element(1'b0, "chain head");
    for (int k = 0; k < 2; k++) run_element(1'b0, "chain tail");
    chk(conf_word == 32'h0000_0100, "R9 other conf bits kept", conf_word, 32'h0000_0100);

    // R13 register writes dropped while busy
    wreg(3'd0, 32'h120, 1'b1);
    wreg(3'd1, 32'h220, 1'b1);
    wreg(3'd3, 32'h0C90_0002, 1'b1);
    wreg(3'd4, 32'h0000_0001, 1'b1);
    run_element(1'b1, "busy write");
    run_element(1'b0, "busy write tail");

    repeat (4) tick();
    finish_up();
  end
endmodule